// File: doc/BRIEF.md
# Transmit Holding Empty Interrupt Gate

This block produces the "transmit holding register empty" interrupt request of a UART whose transmitter is fed through a FIFO. When the FIFO runs dry, the request is raised. At start-up, and after any burst too short to fill the FIFO, the request is held back for one character time less the stop bit. This gives the host time to keep writing without servicing a stream of empty events.

The host side supplies two strobes. One is a write strobe into the transmit holding register. The other is a read strobe of the interrupt identification register, together with a flag saying this source is the one being reported. The transmit side supplies the FIFO empty flag and occupancy, the 16x baud tick, and the frame shape (data length and parity enable). The serializer and the interrupt priority encoder sit outside this block.

Top module: `txe_irq_gate`

## Requirements
- R1: After reset `thre_irq` is low and the fill memory is clear. The first empty event after reset therefore takes the delayed path: with a tick on every clock, `thre_irq` is first seen high at the 1+N-th clock after reset is released.
- R2: `thre_irq` rises only in the cycle after one in which `tx_empty` was high and `thr_wr` was low.
- R3: If `tx_level` was 2 or more in any cycle since the last assertion, `thre_irq` rises on the first clock edge that sees `tx_empty` high.
- R4: Otherwise the delayed path applies. After the edge that first sees `tx_empty` high, `thre_irq` rises on the N-th following edge at which `baud_tick` is high. N = OSR × (1 + D + P), where D = 5 + `data_len` (`data_len` 0..3 selects 5..8 data bits) and P = `parity_on`. Clocks without a tick do not count.
- R5: A `thr_wr` clears `thre_irq` on the next edge. It also aborts a running delay, so the next empty event times a full N ticks from zero. This holds even when the write falls on the edge where the delay would have expired.
- R6: A read strobe `iir_rd` with `iir_thre_top` high clears `thre_irq` on the next edge.
- R7: A read strobe with `iir_thre_top` low leaves `thre_irq` unchanged.
- R8: Each empty event raises `thre_irq` at most once. After a read clears it, it stays low while the FIFO stays empty.
- R9: Each assertion clears the fill memory. A later empty event that follows a load of only one character takes the delayed path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| thr_wr | input | 1 | Host write to the transmit holding register |
| iir_rd | input | 1 | Host read of the interrupt identification register |
| iir_thre_top | input | 1 | This source is the highest one reported at that read |
| baud_tick | input | 1 | One-cycle pulse at 16x baud rate |
| data_len | input | 2 | Data bits minus five |
| parity_on | input | 1 | Parity bit present in the frame |
| thre_irq | output | 1 | Transmit holding empty request pending |

## Verification
Two pairs of events can land on the same clock edge. The first is a host write and the expiry of the character delay; there the write must win, leaving the request low and the timer rearmed. The second is a host read that names this source, arriving together with a write. The bench provokes the first pair by holding `tx_empty` high while pulsing `thr_wr` exactly on the N-th tick of a delay. It then checks that the request stays low and that the following empty event again takes a full N ticks. A behavioural model advances on every clock and judges each cycle, including ones where ticks arrive only every other clock.

// File: rtl/txe_irq_pkg.sv
package txe_irq_pkg;

    // Gate progress for one empty event
    typedef enum logic [1:0] {
        GATE_ARMED  = 2'd0,   // waiting to see the FIFO empty
        GATE_DELAY  = 2'd1,   // timing one character less stop bit
        GATE_SERVED = 2'd2    // request raised for this empty event
    } gate_state_e;

    // Host-side events folded into one bundle
    typedef struct packed {
        logic wr;        // holding register write
        logic rd_clear;  // identification read naming this source
    } host_ev_t;

    // Control decisions made by the sequencer each cycle
    typedef struct packed {
        logic run;       // timer allowed to advance
        logic fire;      // raise the request now
    } gate_ctl_t;

    localparam int unsigned START_BITS     = 1;
    localparam int unsigned MIN_DATA_BITS  = 5;
    localparam int unsigned MAX_FRAME_BITS = START_BITS + 8 + 1;

    // Ticks in one character without its stop bit
    function automatic int unsigned frame_ticks(input logic [1:0] dlen,
                                                input logic       par,
                                                input int unsigned osr);
        int unsigned bits;
        bits = START_BITS + MIN_DATA_BITS + int'(dlen) + (par ? 1 : 0);
        return osr * bits;
    endfunction

endpackage

// File: rtl/txe_fill_memory.sv
module txe_fill_memory #(
    parameter int LVL_W       = 5,
    parameter int HOLD_THRESH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic             fire,
    output logic             held
);
    localparam logic [LVL_W-1:0] THRESH = LVL_W'(HOLD_THRESH);

    logic held_q;
    logic reach;

    generate
        if (HOLD_THRESH <= 1) begin : g_any
            assign reach = (level != '0);
        end else begin : g_cmp
            assign reach = (level >= THRESH);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)        held_q <= 1'b0;
        else if (fire)  held_q <= 1'b0;
        else if (reach) held_q <= 1'b1;
    end

    assign held = held_q;
endmodule

// File: rtl/txe_char_timer.sv
module txe_char_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == (limit - TW'(1)));
    assign expire = run && tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt_q <= '0;
        else if (tick)    cnt_q <= at_end ? '0 : cnt_q + TW'(1);
    end
endmodule

// File: rtl/txe_irq_seq.sv
module txe_irq_seq
    import txe_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      empty,
    input  host_ev_t  ev,
    input  logic      held,
    input  logic      expire,
    output gate_ctl_t ctl,
    output logic      pend
);
    gate_state_e state_q, state_d;
    logic        pend_q, pend_d;

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        if (ev.wr || !empty) begin
            state_d = GATE_ARMED;
        end else begin
            unique case (state_q)
                GATE_ARMED: begin
                    if (held) begin
                        ctl.fire = 1'b1;
                        state_d  = GATE_SERVED;
                    end else begin
                        state_d  = GATE_DELAY;
                    end
                end
                GATE_DELAY: begin
                    ctl.run = 1'b1;
                    if (expire) begin
                        ctl.fire = 1'b1;
                        state_d  = GATE_SERVED;
                    end
                end
                GATE_SERVED: state_d = GATE_SERVED;
                default:     state_d = GATE_ARMED;
            endcase
        end
    end

    always_comb begin
        if (ev.wr)            pend_d = 1'b0;
        else if (ctl.fire)    pend_d = 1'b1;
        else if (ev.rd_clear) pend_d = 1'b0;
        else                  pend_d = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_ARMED;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/txe_irq_gate.sv
module txe_irq_gate
    import txe_irq_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int LVL_W       = 5,
    parameter int HOLD_THRESH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_empty,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             iir_thre_top,
    input  logic             baud_tick,
    input  logic [1:0]       data_len,
    input  logic             parity_on,
    output logic             thre_irq
);
    localparam int TW = $clog2(OSR * MAX_FRAME_BITS + 1);

    host_ev_t      ev;
    gate_ctl_t     ctl;
    logic          held2;
    logic          expire;
    logic [TW-1:0] limit;

    assign ev.wr       = thr_wr;
    assign ev.rd_clear = iir_rd && iir_thre_top;
    assign limit       = TW'(frame_ticks(data_len, parity_on, OSR));

    txe_fill_memory #(.LVL_W(LVL_W), .HOLD_THRESH(HOLD_THRESH)) u_fill (
        .clk   (clk),
        .rst   (rst),
        .level (tx_level),
        .fire  (ctl.fire),
        .held  (held2)
    );

    txe_char_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (ctl.run),
        .tick   (baud_tick),
        .limit  (limit),
        .expire (expire)
    );

    txe_irq_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .empty  (tx_empty),
        .ev     (ev),
        .held   (held2),
        .expire (expire),
        .ctl    (ctl),
        .pend   (thre_irq)
    );
endmodule

// File: rtl/txe_irq_gate_chk.sv
module txe_irq_gate_chk #(
    parameter int LVL_W       = 5,
    parameter int HOLD_THRESH = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_empty,
    input logic [LVL_W-1:0] tx_level,
    input logic             thr_wr,
    input logic             iir_rd,
    input logic             iir_thre_top,
    input logic             thre_irq,
    input logic             held2
);
    // R2
    rise_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(thre_irq) |-> $past(tx_empty && !thr_wr));

    // R3
    fill_memory_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_level >= LVL_W'(HOLD_THRESH)) |=> held2);

    // R5
    write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> !thre_irq);

    // R6
    top_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (thre_irq && iir_rd && iir_thre_top) |=> !thre_irq);

    // R7
    pend_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (thre_irq && !thr_wr && !(iir_rd && iir_thre_top)) |=> thre_irq);

    // R9
    memory_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(thre_irq) |-> !held2);
endmodule

bind txe_irq_gate txe_irq_gate_chk #(.LVL_W(LVL_W), .HOLD_THRESH(HOLD_THRESH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_empty     (tx_empty),
    .tx_level     (tx_level),
    .thr_wr       (thr_wr),
    .iir_rd       (iir_rd),
    .iir_thre_top (iir_thre_top),
    .thre_irq     (thre_irq),
    .held2        (held2)
);

// File: tb/txe_irq_gate_tb.sv
`timescale 1ns/1ps
module txe_irq_gate_tb;
    localparam int OSR   = 16;
    localparam int LVL_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LVL_W-1:0] tx_level = '0;
    logic             tx_empty;
    logic             thr_wr = 1'b0;
    logic             iir_rd = 1'b0;
    logic             iir_thre_top = 1'b0;
    logic             baud_tick = 1'b0;
    logic [1:0]       data_len = 2'd3;
    logic             parity_on = 1'b0;
    logic             thre_irq;

    int    total = 0;
    int    bad = 0;
    int    tick_period = 1;
    int    tick_phase = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    assign tx_empty = (tx_level == '0);

    always #10 clk = ~clk;

    txe_irq_gate #(.OSR(OSR), .LVL_W(LVL_W)) u_dut (
        .clk(clk), .rst(rst), .tx_empty(tx_empty), .tx_level(tx_level),
        .thr_wr(thr_wr), .iir_rd(iir_rd), .iir_thre_top(iir_thre_top),
        .baud_tick(baud_tick), .data_len(data_len), .parity_on(parity_on),
        .thre_irq(thre_irq)
    );

    // tick pattern
    always @(negedge clk) begin
        baud_tick  <= (tick_phase == 0);
        tick_phase <= (tick_phase + 1 >= tick_period) ? 0 : tick_phase + 1;
    end

    // behavioural reference
    bit m_pend, m_seen_two;
    int m_phase;          // 0 waiting for empty, 1 timing, 2 done
    int m_ticks;

    function automatic int char_ticks();
        return OSR * (1 + 5 + int'(data_len) + (parity_on ? 1 : 0));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_seen_two = 0; m_phase = 0; m_ticks = 0;
        end else begin
            bit raise;
            bit next_two;
            raise = 0;
            next_two = m_seen_two || (int'(tx_level) >= 2);
            if (thr_wr || !tx_empty) begin
                m_phase = 0; m_ticks = 0;
            end else if (m_phase == 0) begin
                if (m_seen_two) raise = 1; else begin m_phase = 1; m_ticks = 0; end
            end else if (m_phase == 1 && baud_tick) begin
                m_ticks++;
                if (m_ticks == char_ticks()) raise = 1;
            end
            if (raise) begin m_phase = 2; next_two = 0; end
            if (thr_wr) m_pend = 0;
            else if (raise) m_pend = 1;
            else if (iir_rd && iir_thre_top) m_pend = 0;
            m_seen_two = next_two;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            total++;
            if (thre_irq !== m_pend) begin
                bad++;
                $display("FAIL %s model: thre_irq=%0b expected=%0b at %0t", cur_req, thre_irq, m_pend, $time);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push();
        @(negedge clk); thr_wr = 1'b1; tx_level = tx_level + 1'b1;
        @(negedge clk); thr_wr = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); tx_level = tx_level - 1'b1;
    endtask

    // clocks from the drain until thre_irq is seen high
    task automatic measure(output int n);
        n = 0;
        for (int i = 1; i <= 2000; i++) begin
            @(negedge clk);
            if (thre_irq) begin n = i; break; end
        end
    endtask

    task automatic host_read(input bit top);
        @(negedge clk); iir_rd = 1'b1; iir_thre_top = top;
        @(negedge clk); iir_rd = 1'b0; iir_thre_top = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 reset low", thre_irq, 0);
        rst = 1'b0;
        measure(n);
        check("R1 first event delayed", n, 16 * 9 + 1);

        cur_req = "R7";
        host_read(1'b0);
        check("R7 read without top", thre_irq, 1);
        cur_req = "R6";
        host_read(1'b1);
        check("R6 read with top", thre_irq, 0);
        cur_req = "R8";
        repeat (20) @(negedge clk);
        check("R8 single assertion", thre_irq, 0);

        cur_req = "R3";
        push(); push(); pop(); pop();
        measure(n);
        check("R3 immediate", n, 1);

        cur_req = "R5";
        push();
        check("R5 write clears", thre_irq, 0);
        cur_req = "R9";
        pop();
        @(negedge clk);
        check("R9 no immediate", thre_irq, 0);
        measure(n);
        check("R9 delayed again", n, 16 * 9);

        cur_req = "R4";
        host_read(1'b1);
        data_len = 2'd1; parity_on = 1'b1;
        push(); pop();
        measure(n);
        check("R4 len6 parity", n, 16 * 8 + 1);

        host_read(1'b1);
        data_len = 2'd0; parity_on = 1'b1; tick_period = 2;
        push(); pop();
        measure(n);
        check("R4 half tick rate", (n >= 224 && n <= 226) ? 1 : 0, 1);
        tick_period = 1;
        data_len = 2'd3; parity_on = 1'b0;

        cur_req = "R5";
        host_read(1'b1);
        push(); pop();
        repeat (50) @(negedge clk);
        push();
        repeat (10) @(negedge clk);
        pop();
        measure(n);
        check("R5 abort restarts", n, 16 * 9 + 1);

        host_read(1'b1);
        push(); pop();
        repeat (16 * 9) @(negedge clk);
        check("R5 before expiry", thre_irq, 0);
        thr_wr = 1'b1;
        @(negedge clk); thr_wr = 1'b0; tx_level = 1;
        check("R5 write on expiry edge", thre_irq, 0);
        repeat (4) @(negedge clk);
        pop();
        measure(n);
        check("R5 full delay after collision", n, 16 * 9 + 1);

        @(negedge clk); thr_wr = 1'b1; iir_rd = 1'b1; iir_thre_top = 1'b1; tx_level = 1;
        @(negedge clk); thr_wr = 1'b0; iir_rd = 1'b0; iir_thre_top = 1'b0;
        check("R5 write with read", thre_irq, 0);
        pop();
        repeat (5) @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule